// File: doc/BRIEF.md
# Prioritized Interrupt Claim Controller

This block gathers level-sensitive interrupt requests from a set of peripheral sources and presents one external-interrupt line to a single hart running at one privilege level. Every source has a pending flag, an enable flag and a small priority value. The hart holds a priority threshold of its own. A source counts as eligible when it is pending, enabled and has a priority strictly above that threshold. The interrupt line is high while any source is eligible.

The hart services an interrupt in two steps. It first reads the claim register, which returns the identifier of the best eligible source and clears that source's pending flag. Once its handler is done, it writes the same identifier back to the claim register to signal completion. Between the claim and the completion, the source's request line is masked and cannot set its pending flag again. Identifier 0 is reserved and means that no source is eligible.

Access is through a simple word-addressed register port. A write takes effect on the clock edge where `regWe` is high. Read data is combinational while `regRe` is high, and a claim read takes effect on that same clock edge.

Top module: `intc_claim_top`

## Requirements
- R1: After reset, every priority, enable bit, pending bit and the threshold read 0, a claim read returns 0, and `irqOut` is low.
- R2: A high level on `irqIn[k-1]` sets the pending bit of source k one clock later. Pending words are at word addresses 0x100 to 0x107, with source k in word k/32 at bit k%32. Bit 0 of word 0 always reads 0, and writes to pending words are ignored.
- R3: `irqOut` is high exactly when some source is pending, enabled and has a priority strictly greater than the threshold. A priority of 0 never raises it.
- R4: A claim read at word 0x121 returns the eligible source with the highest priority. Ties go to the lowest identifier, and the read returns 0 when no source is eligible.
- R5: A claim that returns a nonzero identifier clears that source's pending bit. From then on, that source's request line cannot set pending until a completion arrives.
- R6: Writing the claimed identifier to word 0x121 ends the claim. If the request is still high, the pending bit sets again on the following clock.
- R7: A completion write carrying an identifier that is not currently claimed (including 0 and values above the source count) changes nothing.
- R8: Priorities sit at word address equal to the source identifier (0x000 to 0x0FF), in bits [PRIO_W-1:0]. Slot 0 and slots above the source count read 0, and writes to them are ignored.
- R9: Enable words are at 0x110 to 0x117, with source k in word k/32 at bit k%32. Bits without a source (including bit 0 of word 0) read 0.
- R10: The threshold is a PRIO_W-bit value at word 0x120, and the claim register is the next word, 0x121.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (a claim read takes effect on this edge) |
| regAddr | input | 10 | Word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid while regRe is high |
| irqIn | input | NUM_SRC | Level requests; bit k-1 belongs to source k |
| irqOut | output | 1 | External interrupt to the hart |

## Verification
The assertions check several properties on every cycle:
- Any claim read returns an identifier within range.
- The returned identifier is nonzero exactly when `irqOut` is high.
- The reserved slot 0 reads as 0 in the priority, pending and enable views.
- A threshold write at the maximum value silences the interrupt line on the next cycle.

Other behaviours depend on ordered sequences of claims, completions and request levels, so only the bench scenarios can show them:
- Masking a source between its claim and its completion.
- Re-pending a source after completion.
- Ignoring completions of identifiers that are not claimed.
- Choosing the winner when priorities tie.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W     = 10;
  localparam int DATA_W     = 32;
  localparam int WORD_SLOTS = 8;

  localparam logic [ADDR_W-1:0] PRIO_BASE  = 10'h000;
  localparam logic [ADDR_W-1:0] PEND_BASE  = 10'h100;
  localparam logic [ADDR_W-1:0] EN_BASE    = 10'h110;
  localparam logic [ADDR_W-1:0] THR_ADDR   = 10'h120;
  localparam logic [ADDR_W-1:0] CLAIM_ADDR = 10'h121;

  typedef enum logic [2:0] {
    RD_NONE, RD_PRIO, RD_PEND, RD_EN, RD_THR, RD_CLAIM
  } rdSel_e;

  typedef struct packed {
    logic   prioWe;
    logic   enWe;
    logic   thrWe;
    logic   claimRd;
    logic   complWr;
    rdSel_e rdSel;
    logic [7:0] idx;
  } ctlStrobe_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  output ctlStrobe_t        ctl
);
  logic inPrio, inPend, inEn, isThr, isClaim;

  always_comb begin
    inPrio  = (regAddr[ADDR_W-1:8] == PRIO_BASE[ADDR_W-1:8]);
    inPend  = (regAddr[ADDR_W-1:3] == PEND_BASE[ADDR_W-1:3]);
    inEn    = (regAddr[ADDR_W-1:3] == EN_BASE[ADDR_W-1:3]);
    isThr   = (regAddr == THR_ADDR);
    isClaim = (regAddr == CLAIM_ADDR);

    ctl         = '0;
    ctl.idx     = inPrio ? regAddr[7:0] : {5'b0, regAddr[2:0]};
    ctl.prioWe  = regWe && inPrio;
    ctl.enWe    = regWe && inEn;
    ctl.thrWe   = regWe && isThr;
    ctl.complWr = regWe && isClaim;
    ctl.claimRd = regRe && isClaim;

    ctl.rdSel = RD_NONE;
    if (regRe) begin
      if (inPrio)       ctl.rdSel = RD_PRIO;
      else if (inPend)  ctl.rdSel = RD_PEND;
      else if (inEn)    ctl.rdSel = RD_EN;
      else if (isThr)   ctl.rdSel = RD_THR;
      else if (isClaim) ctl.rdSel = RD_CLAIM;
    end
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 26,
  parameter int PRIO_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic [DATA_W-1:0] rdata,
  output logic              irqOut
);
  localparam int SRC_W  = $clog2(NUM_SRC + 1);
  localparam int FLAT_W = WORD_SLOTS * 32;

  logic [PRIO_W-1:0] prioQ    [1:NUM_SRC];
  logic [PRIO_W-1:0] prioNext [1:NUM_SRC];
  logic [NUM_SRC:1]  enQ, pendQ, claimedQ;
  logic [NUM_SRC:1]  enNext, pendNext, claimedNext;
  logic [PRIO_W-1:0] thrQ;
  logic [SRC_W-1:0]  bestId;
  logic [PRIO_W-1:0] bestPrio;
  logic [FLAT_W-1:0] pendFlat, enFlat;

  // per-source next-state logic
  for (genvar g = 1; g <= NUM_SRC; g++) begin : gSrc
    localparam logic [7:0]        ID8  = 8'(g);
    localparam logic [7:0]        WRD  = 8'(g / 32);
    localparam logic [SRC_W-1:0]  IDS  = SRC_W'(g);
    localparam logic [DATA_W-1:0] IDW  = DATA_W'(g);
    logic claimHit, complHit;
    assign claimHit       = ctl.claimRd && (bestId == IDS);
    assign complHit       = ctl.complWr && (wdata == IDW);
    assign prioNext[g]    = (ctl.prioWe && ctl.idx == ID8) ? wdata[PRIO_W-1:0] : prioQ[g];
    assign enNext[g]      = (ctl.enWe && ctl.idx == WRD) ? wdata[g % 32] : enQ[g];
    assign pendNext[g]    = claimHit ? 1'b0 : (pendQ[g] | (irqIn[g-1] & ~claimedQ[g]));
    assign claimedNext[g] = claimHit ? 1'b1 : (complHit ? 1'b0 : claimedQ[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prioQ    <= '{default: '0};
      enQ      <= '0;
      pendQ    <= '0;
      claimedQ <= '0;
      thrQ     <= '0;
    end else begin
      prioQ    <= prioNext;
      enQ      <= enNext;
      pendQ    <= pendNext;
      claimedQ <= claimedNext;
      if (ctl.thrWe) thrQ <= wdata[PRIO_W-1:0];
    end
  end

  // ascending scan: strict compare keeps the lowest id on ties
  always_comb begin
    bestPrio = thrQ;
    bestId   = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (pendQ[i] && enQ[i] && (prioQ[i] > bestPrio)) begin
        bestPrio = prioQ[i];
        bestId   = SRC_W'(i);
      end
    end
  end

  assign irqOut = (bestId != '0);

  always_comb begin
    pendFlat = '0;
    enFlat   = '0;
    pendFlat[NUM_SRC:1] = pendQ;
    enFlat[NUM_SRC:1]   = enQ;
  end

  always_comb begin
    rdata = '0;
    case (ctl.rdSel)
      RD_PRIO: begin
        for (int i = 1; i <= NUM_SRC; i++)
          if (ctl.idx == 8'(i)) rdata = DATA_W'(prioQ[i]);
      end
      RD_PEND:  rdata = pendFlat[{ctl.idx[2:0], 5'b0} +: 32];
      RD_EN:    rdata = enFlat[{ctl.idx[2:0], 5'b0} +: 32];
      RD_THR:   rdata = DATA_W'(thrQ);
      RD_CLAIM: rdata = DATA_W'(bestId);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/intc_claim_top.sv
module intc_claim_top
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 26,
  parameter int PRIO_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic               regRe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic               irqOut
);
  ctlStrobe_t ctl;

  intc_ctrl u_ctrl (
    .regWe   (regWe),
    .regRe   (regRe),
    .regAddr (regAddr),
    .ctl     (ctl)
  );

  intc_datapath #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .wdata  (regWdata),
    .irqIn  (irqIn),
    .rdata  (regRdata),
    .irqOut (irqOut)
  );
endmodule

// File: rtl/intc_claim_chk.sv
module intc_claim_chk
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 26,
  parameter int PRIO_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic              regRe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              irqOut
);
  p_claim_vs_irq_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && regAddr == CLAIM_ADDR) |-> ((regRdata != '0) == irqOut));

  p_claim_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && regAddr == CLAIM_ADDR) |-> (regRdata <= DATA_W'(NUM_SRC)));

  p_thr_max_silences_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == THR_ADDR && regWdata[PRIO_W-1:0] == {PRIO_W{1'b1}}) |=> !irqOut);

  p_reserved_slot_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && regAddr == PRIO_BASE) |-> (regRdata == '0));

  p_src0_pend_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && regAddr == PEND_BASE) |-> !regRdata[0]);

  p_src0_en_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && regAddr == EN_BASE) |-> !regRdata[0]);
endmodule

bind intc_claim_top intc_claim_chk #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWe    (regWe),
  .regRe    (regRe),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .regRdata (regRdata),
  .irqOut   (irqOut)
);

// File: tb/test_intc_claim_top.sv
`timescale 1ns/1ps
module test_intc_claim_top;
  import intc_pkg::*;
  localparam int NS = 26;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0, regRe = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic [NS-1:0] irqIn = '0;
  logic irqOut;

  intc_claim_top #(.NUM_SRC(NS), .PRIO_W(PW)) i_intc_claim_top (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqIn(irqIn), .irqOut(irqOut)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int prioM [0:NS];
  bit enM [0:NS], pendM [0:NS], claimedM [0:NS];
  int thrM = 0;
  logic [NS-1:0] irqVec = '0;
  logic [31:0] lastRd;
  logic lastIrq;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic int bestM();
    int bp = thrM, id = 0;
    for (int i = 1; i <= NS; i++)
      if (pendM[i] && enM[i] && prioM[i] > bp) begin bp = prioM[i]; id = i; end
    return id;
  endfunction

  function automatic logic [31:0] mread(input logic [ADDR_W-1:0] a);
    logic [31:0] v = '0;
    if (a[9:8] == 2'b00) begin
      if (a >= 1 && a <= NS) v = 32'(prioM[a]);
    end else if (a[9:3] == PEND_BASE[9:3] || a[9:3] == EN_BASE[9:3]) begin
      for (int i = 1; i <= NS; i++)
        if (i / 32 == int'(a[2:0]))
          v[i % 32] = (a[9:3] == PEND_BASE[9:3]) ? pendM[i] : enM[i];
    end else if (a == THR_ADDR) v = 32'(thrM);
    else if (a == CLAIM_ADDR) v = 32'(bestM());
    return v;
  endfunction

  function automatic string tagOf(input logic [ADDR_W-1:0] a);
    if (a[9:8] == 2'b00) return "R8";
    if (a[9:3] == PEND_BASE[9:3]) return "R2";
    if (a[9:3] == EN_BASE[9:3]) return "R9";
    if (a == THR_ADDR) return "R10";
    if (a == CLAIM_ADDR) return "R4";
    return "R10";
  endfunction

  // one clock cycle: drive, sample, update the model, take the edge
  task automatic op(input bit we, input bit re, input logic [ADDR_W-1:0] a, input logic [31:0] d);
    int b;
    bit cl;
    @(negedge clk);
    regWe = we; regRe = re; regAddr = a; regWdata = d; irqIn = irqVec;
    #1;
    b = bestM();
    lastIrq = irqOut;
    lastRd = regRdata;
    chk("R3", {31'b0, irqOut}, (b != 0) ? 32'd1 : 32'd0);
    if (re) chk(tagOf(a), regRdata, mread(a));
    cl = re && (a == CLAIM_ADDR) && (b != 0);
    for (int i = 1; i <= NS; i++) begin
      if (cl && b == i) begin pendM[i] = 0; claimedM[i] = 1; end
      else begin
        pendM[i] = pendM[i] | (irqVec[i-1] & ~claimedM[i]);
        if (we && a == CLAIM_ADDR && d == 32'(i)) claimedM[i] = 0;
      end
    end
    if (we && a[9:8] == 2'b00 && a >= 1 && a <= NS) prioM[a] = int'(d[PW-1:0]);
    if (we && a[9:3] == EN_BASE[9:3])
      for (int i = 1; i <= NS; i++) if (i / 32 == int'(a[2:0])) enM[i] = d[i % 32];
    if (we && a == THR_ADDR) thrM = int'(d[PW-1:0]);
    @(posedge clk);
  endtask

  task automatic idle();
    op(0, 0, '0, '0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i <= NS; i++) begin prioM[i] = 0; enM[i] = 0; pendM[i] = 0; claimedM[i] = 0; end
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    op(0, 1, CLAIM_ADDR, 0);     chk("R1", lastRd, 0);
    chk("R1", {31'b0, lastIrq}, 0);
    op(0, 1, THR_ADDR, 0);       chk("R1", lastRd, 0);
    op(0, 1, PRIO_BASE + 3, 0);  chk("R1", lastRd, 0);
    op(0, 1, PEND_BASE, 0);      chk("R1", lastRd, 0);
    op(0, 1, EN_BASE, 0);        chk("R1", lastRd, 0);

    // setup
    op(1, 0, 10'd5, 3); op(1, 0, 10'd9, 3); op(1, 0, 10'd12, 6);
    op(1, 0, EN_BASE, 32'hFFFF_FFFF);
    op(0, 1, EN_BASE, 0);        chk("R9", lastRd, 32'h07FF_FFFE);

    // R2 pending
    irqVec = (26'd1 << 4) | (26'd1 << 8);
    idle();
    op(0, 1, PEND_BASE, 0);      chk("R2", lastRd, 32'h0000_0220);
    op(1, 0, PEND_BASE, 32'hFFFF_FFFF);
    op(0, 1, PEND_BASE, 0);      chk("R2", lastRd, 32'h0000_0220);
    chk("R3", {31'b0, lastIrq}, 1);

    // R4 tie order, R5 masking
    op(0, 1, CLAIM_ADDR, 0);     chk("R4", lastRd, 5);
    op(0, 1, CLAIM_ADDR, 0);     chk("R4", lastRd, 9);
    op(0, 1, CLAIM_ADDR, 0);     chk("R4", lastRd, 0);
    idle(); idle();
    op(0, 1, PEND_BASE, 0);      chk("R5", lastRd, 0);
    chk("R5", {31'b0, lastIrq}, 0);

    // R7 bogus completions
    op(1, 0, CLAIM_ADDR, 3); op(1, 0, CLAIM_ADDR, 0); op(1, 0, CLAIM_ADDR, 27);
    idle();
    op(0, 1, PEND_BASE, 0);      chk("R7", lastRd, 0);

    // R6 completion re-arms a still-high source
    op(1, 0, CLAIM_ADDR, 5);
    idle();
    op(0, 1, PEND_BASE, 0);      chk("R6", lastRd, 32'h0000_0020);
    chk("R6", {31'b0, lastIrq}, 1);

    // R10 threshold and claim word, R3 strict compare
    op(1, 0, THR_ADDR, 3);
    op(0, 1, THR_ADDR, 0);       chk("R10", lastRd, 3);
    chk("R3", {31'b0, lastIrq}, 0);
    op(0, 1, CLAIM_ADDR, 0);     chk("R10", lastRd, 0);
    op(1, 0, THR_ADDR, 2);
    op(0, 1, CLAIM_ADDR, 0);     chk("R10", lastRd, 5);

    // R4 priority beats lower id
    irqVec = irqVec | (26'd1 << 11);
    idle();
    op(0, 1, CLAIM_ADDR, 0);     chk("R4", lastRd, 12);

    // R8 reserved slot and field width
    op(1, 0, PRIO_BASE, 7);
    op(0, 1, PRIO_BASE, 0);      chk("R8", lastRd, 0);
    op(1, 0, 10'd12, 32'hF);
    op(0, 1, 10'd12, 0);         chk("R8", lastRd, 7);
    op(1, 0, 10'd30, 5);
    op(0, 1, 10'd30, 0);         chk("R8", lastRd, 0);

    // random phase against the model
    for (int n = 0; n < 3000; n++) begin
      int r;
      if ($urandom % 4 == 0) irqVec = NS'($urandom);
      r = int'($urandom % 8);
      case (r)
        0: op(1, 0, 10'($urandom % 32), $urandom);
        1: op(1, 0, EN_BASE + 10'($urandom % 2), $urandom);
        2: op(1, 0, THR_ADDR, $urandom % 8);
        3, 4: op(0, 1, CLAIM_ADDR, 0);
        5: op(1, 0, CLAIM_ADDR, $urandom % 32);
        6: begin
          int s = int'($urandom % 5);
          logic [ADDR_W-1:0] a;
          a = (s == 0) ? 10'($urandom % 32) : (s == 1) ? PEND_BASE + 10'($urandom % 2) :
              (s == 2) ? EN_BASE + 10'($urandom % 2) : (s == 3) ? THR_ADDR : CLAIM_ADDR;
          op(0, 1, a, 0);
        end
        default: idle();
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule